// File: doc/BRIEF.md
# Buffered Serial Transmitter with Break Generation

This block is an asynchronous serial transmit engine. A host hands it one word at a time over a small strobe interface. The word is either 8 data bits or 8 data bits plus a separately supplied ninth bit. The block frames the word with a low start bit, the data bits sent least significant first, an optional even or odd parity bit, and one or two high stop bits. Each bit lasts `divisor + 1` clock cycles.

A one-word holding buffer sits in front of the shift register, so the host can queue the next word while the current frame is still going out. Words are then sent back to back with no idle gap. Two flags follow the data path: `buf_empty` and `tx_idle`. A word is accepted only if the host pulsed the status-read strobe after the last data write and the buffer is empty. Any other write is dropped.

Raising `break_req` makes the next frame a break. A break is a start bit followed by low bits in blocks of 13. A new block follows for as long as `break_req` stays high. When `break_req` drops, the block in progress finishes and the configured stop bits follow. The interrupt output reports an empty buffer when enabled, and it stays quiet during a break frame.

Top module: `uart_tx_buffered`

## Requirements
- R1: A data frame drives `txd` low for one start bit, then sends the data bits least significant bit first, then sends high stop bits. Every bit lasts exactly `divisor + 1` clock cycles.
- R2: With `nine_bit`=0 a frame carries the 8 bits of `wr_byte`. With `nine_bit`=1 it carries 9 bits, and the ninth (last) data bit is the value of `wr_bit8` captured with the write.
- R3: With `parity_en`=1 one parity bit follows the last data bit. Its value is the XOR of all data bits in the frame, including the ninth bit in 9-bit mode. That value is inverted when `parity_odd`=1, so the total count of ones becomes odd.
- R4: `two_stop`=0 gives one stop bit and `two_stop`=1 gives two. The line stays high after the last stop bit when nothing is queued.
- R5: An accepted write while no frame is in progress starts the frame at once: `txd` shows the start bit in the cycle after the write, and `buf_empty` stays 1.
- R6: An accepted write during a frame fills the holding buffer (`buf_empty`=0). The word is sent starting in the cycle right after the current frame's last stop bit, and `buf_empty` returns to 1 at that point.
- R7: A data write is accepted only if `stat_rd` was pulsed after the previous `data_wr` and `buf_empty`=1. Every `data_wr` strobe uses up the pending status read. A write that is not accepted changes nothing.
- R8: `tx_idle` is 1 after reset. It is also 1 after a frame (data or break) ends with nothing following. An accepted write clears it, and so does the start of a break. While `tx_idle`=1 the line is high.
- R9: While `break_req`=1 with the transmitter free, a break frame starts. A break is one start bit plus 13×N low bits, where N counts the 13-bit blocks begun while `break_req` was still high. The break is followed by the configured stop bits.
- R10: `irq` = `irq_enable` AND `tx_enable` AND `buf_empty`, and it is forced to 0 for the whole of a break frame, including its stop bits.
- R11: With `tx_enable`=0 the line is high, any queued word is dropped, `buf_empty`=1 and `tx_idle`=1 from the next cycle on. Re-enabling does not send the dropped word.
- R12: After reset the outputs are `txd`=1, `buf_empty`=1 and `tx_idle`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Transmitter enable; low holds the line high and drops queued data |
| divisor | input | DIV_W | Bit period minus one, in clock cycles |
| nine_bit | input | 1 | Selects 9 data bits |
| parity_en | input | 1 | Adds a parity bit |
| parity_odd | input | 1 | Selects odd parity when 1, even when 0 |
| two_stop | input | 1 | Selects two stop bits |
| break_req | input | 1 | Requests break frames |
| irq_enable | input | 1 | Enables the buffer-empty interrupt |
| stat_rd | input | 1 | Status read strobe; arms the next data write |
| data_wr | input | 1 | Data write strobe |
| wr_byte | input | DATA_W | Low data bits of the written word |
| wr_bit8 | input | 1 | Ninth data bit of the written word |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding buffer can take a word |
| tx_idle | output | 1 | No frame in progress or queued |
| irq | output | 1 | Buffer-empty interrupt |

## Verification
The bench sweeps every combination of word length, parity mode and stop count across three divisors, and it sends all 512 nine-bit words under odd parity. A wrong bit order, a parity computed without the ninth bit, or a bit period off by one would therefore show up as a wrong line level in some cycle.

It queues a word mid-frame and expects that word to start in the very cycle after the stop bit. A design that idles between frames, or that forgets to refill the buffer flag, fails here. It also sends a write with no fresh status read and a write into a full buffer; a design that accepts either one transmits an extra frame.

Break frames with one, two and three blocks are checked cycle by cycle against the 13-bit granularity, with `irq` expected low throughout. A design that stops the break as soon as `break_req` drops, or that signals an interrupt during a break, is caught. Finally, dropping the enable with a word queued must leave a silent line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_BRK
   } tx_state_e;

   typedef struct packed {
      logic nine;
      logic par_en;
      logic par_odd;
      logic two_stop;
   } frame_cfg_t;

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [DIV_W-1:0] divisor,
   output logic             bit_end
);

   logic [DIV_W-1:0] cnt_q;

   assign bit_end = run & (cnt_q == divisor);

   // Restarted at every frame start; wraps at every bit boundary.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || !run || (cnt_q == divisor)) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
   parameter int DATA_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            stat_rd,
   input  logic            data_wr,
   input  logic [DATA_W:0] wr_word,
   input  logic            take_direct,
   input  logic            take_buf,
   input  logic            start_brk,
   input  logic            start_any,
   input  logic            frame_done,
   output logic            wr_ok,
   output logic            pend,
   output logic [DATA_W:0] buf_word,
   output logic            idle
);

   logic armed_q;

   assign wr_ok = en & data_wr & armed_q & ~pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         pend     <= 1'b0;
         buf_word <= '0;
         idle     <= 1'b1;
      end else if (!en) begin
         armed_q <= 1'b0;
         pend    <= 1'b0;
         idle    <= 1'b1;
      end else begin
         // A status read arms exactly one following data strobe.
         armed_q <= stat_rd | (armed_q & ~data_wr);
         if (wr_ok && !take_direct) begin
            pend     <= 1'b1;
            buf_word <= wr_word;
         end else if (take_buf) begin
            pend <= 1'b0;
         end
         if (wr_ok || start_brk) begin
            idle <= 1'b0;
         end else if (frame_done && !start_any) begin
            idle <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
   import uart_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int BREAK_BITS = 13,
   parameter int CNT_W      = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            bit_end,
   input  logic            brk_req,
   input  frame_cfg_t      cfg,
   input  logic            wr_ok,
   input  logic [DATA_W:0] wr_word,
   input  logic            pend,
   input  logic [DATA_W:0] buf_word,
   output logic            start_brk,
   output logic            take_buf,
   output logic            take_direct,
   output logic            start_any,
   output logic            frame_done,
   output logic            busy,
   output logic            brk_busy,
   output logic            line
);

   localparam logic [CNT_W-1:0] LAST_LO  = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] LAST_HI  = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] BRK_LAST = CNT_W'(BREAK_BITS - 1);

   tx_state_e        state_q;
   logic [DATA_W:0]  shreg_q;
   logic             par_q;
   frame_cfg_t       cfg_q;
   logic             is_brk_q;
   logic [CNT_W-1:0] bcnt_q;
   logic             scnt_q;
   logic             free;
   logic [DATA_W:0]  load_word;
   logic [DATA_W:0]  par_mask;
   logic             par_n;
   logic [CNT_W-1:0] last_bit;

   assign busy       = (state_q != ST_IDLE);
   assign brk_busy   = is_brk_q & busy;
   assign frame_done = (state_q == ST_STOP) & bit_end & (~cfg_q.two_stop | scnt_q);
   assign free       = ~busy | frame_done;

   // Priority at a free slot: break, then the queued word, then a fresh write.
   assign start_brk   = en & free & brk_req;
   assign take_buf    = en & free & ~brk_req & pend;
   assign take_direct = en & free & ~brk_req & ~pend & wr_ok;
   assign start_any   = start_brk | take_buf | take_direct;

   assign load_word = take_buf ? buf_word : wr_word;
   assign par_mask  = {cfg.nine, {DATA_W{1'b1}}};
   assign par_n     = (^(load_word & par_mask)) ^ cfg.par_odd;
   assign last_bit  = cfg_q.nine ? LAST_HI : LAST_LO;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         shreg_q  <= '0;
         par_q    <= 1'b0;
         cfg_q    <= '0;
         is_brk_q <= 1'b0;
         bcnt_q   <= '0;
         scnt_q   <= 1'b0;
      end else if (!en) begin
         state_q  <= ST_IDLE;
         is_brk_q <= 1'b0;
      end else if (start_any) begin
         state_q  <= ST_START;
         shreg_q  <= load_word;
         par_q    <= par_n;
         cfg_q    <= cfg;
         is_brk_q <= start_brk;
         bcnt_q   <= '0;
         scnt_q   <= 1'b0;
      end else if (frame_done) begin
         state_q  <= ST_IDLE;
         is_brk_q <= 1'b0;
      end else if (bit_end) begin
         unique case (state_q)
            ST_START: begin
               state_q <= is_brk_q ? ST_BRK : ST_DATA;
               bcnt_q  <= '0;
            end
            ST_DATA: begin
               shreg_q <= {1'b0, shreg_q[DATA_W:1]};
               if (bcnt_q == last_bit) begin
                  state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
               end else begin
                  bcnt_q <= bcnt_q + CNT_W'(1);
               end
            end
            ST_PAR: begin
               state_q <= ST_STOP;
            end
            ST_STOP: begin
               scnt_q <= 1'b1;
            end
            ST_BRK: begin
               if (bcnt_q == BRK_LAST) begin
                  bcnt_q <= '0;
                  if (!brk_req) begin
                     state_q <= ST_STOP;
                  end
               end else begin
                  bcnt_q <= bcnt_q + CNT_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (state_q)
         ST_START: line = 1'b0;
         ST_DATA:  line = shreg_q[0];
         ST_PAR:   line = par_q;
         ST_BRK:   line = 1'b0;
         default:  line = 1'b1;
      endcase
   end

endmodule

// File: rtl/uart_tx_buffered.sv
module uart_tx_buffered
   import uart_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int DIV_W      = 8,
   parameter int BREAK_BITS = 13,
   parameter bit REG_OUT    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_enable,
   input  logic [DIV_W-1:0]  divisor,
   input  logic              nine_bit,
   input  logic              parity_en,
   input  logic              parity_odd,
   input  logic              two_stop,
   input  logic              break_req,
   input  logic              irq_enable,
   input  logic              stat_rd,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              wr_bit8,
   output logic              txd,
   output logic              buf_empty,
   output logic              tx_idle,
   output logic              irq
);

   localparam int MAX_CNT = (DATA_W + 1 > BREAK_BITS) ? DATA_W + 1 : BREAK_BITS;
   localparam int CNT_W   = $clog2(MAX_CNT + 1);

   if (DATA_W < 5 || DATA_W > 16) begin : g_bad_data_w
      $error("DATA_W must lie in 5..16");
   end
   if (DIV_W < 1 || DIV_W > 24) begin : g_bad_div_w
      $error("DIV_W must lie in 1..24");
   end
   if (BREAK_BITS < 1) begin : g_bad_break
      $error("BREAK_BITS must be at least 1");
   end

   frame_cfg_t      cfg;
   logic [DATA_W:0] wr_word;
   logic [DATA_W:0] buf_word;
   logic            wr_ok, pend;
   logic            start_brk, take_buf, take_direct, start_any;
   logic            frame_done, busy, brk_busy, line;
   logic            bit_end;

   assign cfg     = '{nine: nine_bit, par_en: parity_en, par_odd: parity_odd, two_stop: two_stop};
   assign wr_word = {wr_bit8, wr_byte};

   uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .clr     (start_any),
      .divisor (divisor),
      .bit_end (bit_end)
   );

   uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (tx_enable),
      .stat_rd     (stat_rd),
      .data_wr     (data_wr),
      .wr_word     (wr_word),
      .take_direct (take_direct),
      .take_buf    (take_buf),
      .start_brk   (start_brk),
      .start_any   (start_any),
      .frame_done  (frame_done),
      .wr_ok       (wr_ok),
      .pend        (pend),
      .buf_word    (buf_word),
      .idle        (tx_idle)
   );

   uart_tx_shift #(
      .DATA_W     (DATA_W),
      .BREAK_BITS (BREAK_BITS),
      .CNT_W      (CNT_W)
   ) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (tx_enable),
      .bit_end     (bit_end),
      .brk_req     (break_req),
      .cfg         (cfg),
      .wr_ok       (wr_ok),
      .wr_word     (wr_word),
      .pend        (pend),
      .buf_word    (buf_word),
      .start_brk   (start_brk),
      .take_buf    (take_buf),
      .take_direct (take_direct),
      .start_any   (start_any),
      .frame_done  (frame_done),
      .busy        (busy),
      .brk_busy    (brk_busy),
      .line        (line)
   );

   if (REG_OUT) begin : g_line_reg
      logic txd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            txd_q <= 1'b1;
         end else begin
            txd_q <= tx_enable ? line : 1'b1;
         end
      end
      assign txd = txd_q;
   end else begin : g_line_comb
      assign txd = line;
   end

   assign buf_empty = ~pend;
   assign irq       = irq_enable & tx_enable & ~pend & ~brk_busy;

endmodule

// File: rtl/uart_tx_buffered_chk.sv
module uart_tx_buffered_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_enable,
   input logic data_wr,
   input logic irq_enable,
   input logic txd,
   input logic buf_empty,
   input logic tx_idle,
   input logic irq
);

   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      tx_idle |-> txd);  // R8

   AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_enable |=> (txd && buf_empty && tx_idle));  // R11

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_enable && tx_enable && buf_empty));  // R10

   AST_FILL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(buf_empty) |-> $past(data_wr && tx_enable));  // R7

endmodule

bind uart_tx_buffered uart_tx_buffered_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_enable  (tx_enable),
   .data_wr    (data_wr),
   .irq_enable (irq_enable),
   .txd        (txd),
   .buf_empty  (buf_empty),
   .tx_idle    (tx_idle),
   .irq        (irq)
);

// File: tb/sim_uart_tx_buffered.sv
module sim_uart_tx_buffered;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_enable = 1'b0;
   logic [7:0] divisor = '0;
   logic       nine_bit = 1'b0, parity_en = 1'b0, parity_odd = 1'b0, two_stop = 1'b0;
   logic       break_req = 1'b0, irq_enable = 1'b0;
   logic       stat_rd = 1'b0, data_wr = 1'b0;
   logic [7:0] wr_byte = '0;
   logic       wr_bit8 = 1'b0;
   logic       txd, buf_empty, tx_idle, irq;

   int vectors = 0;
   int fails   = 0;
   logic exp_bits [0:63];
   int   exp_n = 0;

   always #10 clk = ~clk;

   uart_tx_buffered u0 (
      .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .divisor(divisor),
      .nine_bit(nine_bit), .parity_en(parity_en), .parity_odd(parity_odd),
      .two_stop(two_stop), .break_req(break_req), .irq_enable(irq_enable),
      .stat_rd(stat_rd), .data_wr(data_wr), .wr_byte(wr_byte), .wr_bit8(wr_bit8),
      .txd(txd), .buf_empty(buf_empty), .tx_idle(tx_idle), .irq(irq)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   // Expected line levels for one data frame, appended at exp_n.
   task automatic add_frame(input logic [8:0] w);
      logic p;
      int nb;
      nb = nine_bit ? 9 : 8;
      exp_bits[exp_n] = 1'b0; exp_n++;
      for (int i = 0; i < nb; i++) begin
         exp_bits[exp_n] = w[i]; exp_n++;
      end
      p = 1'b0;
      for (int i = 0; i < nb; i++) p = p ^ w[i];
      p = p ^ parity_odd;
      if (parity_en) begin
         exp_bits[exp_n] = p; exp_n++;
      end
      exp_bits[exp_n] = 1'b1; exp_n++;
      if (two_stop) begin
         exp_bits[exp_n] = 1'b1; exp_n++;
      end
   endtask

   task automatic check_line(input string tag);
      for (int k = 0; k < exp_n; k++) begin
         for (int c = 0; c <= int'(divisor); c++) begin
            chk(tag, {31'd0, txd}, {31'd0, exp_bits[k]});
            step();
         end
      end
   endtask

   // Status read, then data write; returns at the negedge after acceptance.
   task automatic send_word(input logic [8:0] w);
      stat_rd = 1'b1;
      step();
      stat_rd = 1'b0;
      data_wr = 1'b1;
      wr_byte = w[7:0];
      wr_bit8 = w[8];
      step();
      data_wr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      logic [8:0] w;
      repeat (3) step();
      rst_n = 1'b1;
      tx_enable = 1'b1;
      step();
      // R12 reset state
      chk("R12 txd", {31'd0, txd}, 32'd1);
      chk("R12 buf_empty", {31'd0, buf_empty}, 32'd1);
      chk("R12 tx_idle", {31'd0, tx_idle}, 32'd1);
      // R10 masked and unmasked interrupt while idle
      chk("R10 irq masked", {31'd0, irq}, 32'd0);
      irq_enable = 1'b1;
      step();
      chk("R10 irq idle", {31'd0, irq}, 32'd1);

      // R7 write without a status read is dropped
      data_wr = 1'b1; wr_byte = 8'h00;
      step();
      data_wr = 1'b0;
      for (int i = 0; i < 6; i++) begin
         chk("R7 unarmed write", {30'd0, txd, tx_idle}, 32'd3);
         step();
      end

      // R1 R2 R3 R4 R5: sweep of divisor, word length, parity and stop bits
      for (int d = 0; d < 3; d++) begin
         for (int cf = 0; cf < 16; cf++) begin
            for (int p = 0; p < 4; p++) begin
               divisor = 8'(d);
               {nine_bit, parity_en, parity_odd, two_stop} = 4'(cf);
               w = (p == 0) ? 9'h000 : (p == 1) ? 9'h1FF : 9'((p * 157 + cf * 29 + d) & 9'h1FF);
               send_word(w);
               chk("R5 direct keeps buf_empty", {31'd0, buf_empty}, 32'd1);
               chk("R8 idle cleared by write", {31'd0, tx_idle}, 32'd0);
               exp_n = 0;
               add_frame(w);
               check_line("R1 R2 R3 R4 frame");
               chk("R4 R8 idle after frame", {30'd0, txd, tx_idle}, 32'd3);
            end
         end
      end

      // R2 R3: all nine-bit words, odd parity, one stop bit
      divisor = 8'd0;
      {nine_bit, parity_en, parity_odd, two_stop} = 4'b1110;
      for (int v = 0; v < 512; v++) begin
         send_word(9'(v));
         exp_n = 0;
         add_frame(9'(v));
         check_line("R2 R3 nine-bit parity");
      end

      // R6 R7: queued word follows with no gap; stale or full-buffer writes dropped
      divisor = 8'd1;
      {nine_bit, parity_en, parity_odd, two_stop} = 4'b0000;
      send_word(9'h0C3);
      exp_n = 0;
      add_frame(9'h0C3);
      add_frame(9'h05A);
      fork
         check_line("R6 back-to-back frames");
         begin
            repeat (4) step();
            stat_rd = 1'b1;
            step();
            stat_rd = 1'b0; data_wr = 1'b1; wr_byte = 8'h5A; wr_bit8 = 1'b0;
            step();
            data_wr = 1'b0;
            chk("R6 buffer full", {31'd0, buf_empty}, 32'd0);
            chk("R10 irq with full buffer", {31'd0, irq}, 32'd0);
            stat_rd = 1'b1;
            step();
            stat_rd = 1'b0; data_wr = 1'b1; wr_byte = 8'hFF;
            step();
            data_wr = 1'b0;
            repeat (12) step();
            chk("R6 buffer drained", {31'd0, buf_empty}, 32'd1);
            chk("R10 irq on drained buffer", {31'd0, irq}, 32'd1);
            data_wr = 1'b1; wr_byte = 8'h00;
            step();
            data_wr = 1'b0;
         end
      join
      for (int i = 0; i < 24; i++) begin
         chk("R7 dropped writes send nothing", {30'd0, txd, tx_idle}, 32'd3);
         step();
      end

      // R9 R10: break frames of one, two and three blocks
      for (int n = 1; n <= 3; n++) begin
         two_stop = n[0];
         break_req = 1'b1;
         step();
         chk("R9 idle cleared by break", {31'd0, tx_idle}, 32'd0);
         for (int k = 0; k < 1 + 13 * n + (two_stop ? 2 : 1); k++) begin
            for (int c = 0; c <= int'(divisor); c++) begin
               chk("R9 break line", {31'd0, txd}, (k <= 13 * n) ? 32'd0 : 32'd1);
               chk("R10 no irq in break", {31'd0, irq}, 32'd0);
               if (k == 13 * n - 3 && c == 0) break_req = 1'b0;
               step();
            end
         end
         chk("R8 R9 idle after break", {30'd0, txd, tx_idle}, 32'd3);
         chk("R10 irq after break", {31'd0, irq}, 32'd1);
      end

      // R11: disable with a queued word drops it
      two_stop = 1'b0;
      send_word(9'h011);
      repeat (3) step();
      send_word(9'h0EE);
      chk("R11 queued before disable", {31'd0, buf_empty}, 32'd0);
      tx_enable = 1'b0;
      step();
      chk("R11 disabled state", {29'd0, txd, buf_empty, tx_idle}, 32'd7);
      tx_enable = 1'b1;
      for (int i = 0; i < 30; i++) begin
         step();
         chk("R11 dropped word not sent", {30'd0, txd, tx_idle}, 32'd3);
      end

      report();
      $finish;
   end

endmodule